// File: doc/BRIEF.md
# Binary Neuron Cell with XNOR Popcount

This block is a single processing element for a binarized neural network. It keeps a small local store of 32-bit weight words and one activation threshold. Each incoming 32-bit input word is compared bit by bit with a stored weight word through XNOR. The number of agreeing bits is counted by an adder tree. The weight word used is picked by a word pointer inside the cell: the pointer returns to zero on a start marker and moves forward by one on every accepted word.

In sequential mode the cell adds the per-word counts of a whole input vector. The vector runs from the word that carries the start marker to the word that carries the last marker. After the last word the cell compares the total against its threshold, gives one activation bit and raises a one-cycle done pulse. In parallel mode each per-word count is sent out of the cell, together with a valid pulse, for a column adder shared by several cells. The local total is then left untouched.

Top module: `bnn_neuron_cell`

## Requirements
- R1: While reset is applied and in the first cycle after it, `done`, `actOut`, `partValid` and `partCount` are all 0.
- R2: For an accepted word the per-word count equals the number of bit positions where `inData` equals the selected weight word, i.e. popcount(~(inData ^ weight)).
- R3: The per-word count spans the full range 0 to 32. A word that matches its weight in every bit gives 32 on the 6-bit `partCount`.
- R4: The word accepted with `inStart` uses weight word 0. The n-th accepted word after it uses weight word n, in both modes, and the pointer wraps after word 63.
- R5: In sequential mode (`parMode`=0) the total is the sum of the per-word counts from the start word to the last word. `done` is 1 for exactly one cycle, in the cycle after the last word is accepted.
- R6: `actOut` is 1 when the total is greater than or equal to the threshold and 0 when it is below. Equality gives 1. `actOut` holds its value until the next completion.
- R7: In parallel mode (`parMode`=1) `partValid` is 1 and `partCount` carries the word's count in the cycle after the word is accepted. Such a word adds nothing to the sequential total and raises no `done`.
- R8: A start marker discards any earlier partial total. A word that carries both start and last forms a one-word vector.
- R9: A threshold written through `thrWrEn` applies to every completion that follows the write.
- R10: A 64-word vector in which every bit matches sums to 2048 without overflow in the 12-bit total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wtWrEn | input | 1 | Write strobe for the weight store |
| wtWrAddr | input | 6 | Weight word index to write |
| wtWrData | input | 32 | Weight word to write |
| thrWrEn | input | 1 | Write strobe for the threshold |
| thrWrData | input | 12 | Threshold value |
| inValid | input | 1 | Input word present this cycle |
| inStart | input | 1 | Word is the first of a vector |
| inLast | input | 1 | Word is the final one of a vector |
| parMode | input | 1 | 1 = send per-word count out, 0 = accumulate |
| inData | input | 32 | Binary input word |
| actOut | output | 1 | Activation bit of the last completed vector |
| done | output | 1 | One-cycle pulse after a vector completes |
| partValid | output | 1 | Per-word count is valid (parallel mode) |
| partCount | output | 6 | Per-word count for the shared column adder |

## Verification
A parallel-mode sweep over all 64 weight words sets a different number of flipped bits in each input word, so every count from 0 to 32 appears. This also shows whether the pointer picks the right weight word. Sequential vectors of lengths 1, 2, 5 and 64 are run with the threshold set at, one above and one below the expected total, which separates the greater-or-equal rule from an off-by-one compare. A fully matching 64-word vector reaches the 2048 ceiling. Two further runs, one that abandons a vector midway and one that mixes parallel words into a sequential vector, show whether stale or foreign counts reach the total.

// File: rtl/bnn_cell_pkg.sv
package bnn_cell_pkg;
  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic first;   // accepted word opens a vector
    logic seqAdd;  // accepted word goes into the local total
    logic parOut;  // accepted word goes out to the column adder
    logic finish;  // accepted word closes a sequential vector
  } cellCtrl_t;
endpackage

// File: rtl/bnn_popcount_tree.sv
module bnn_popcount_tree #(
  parameter int WordW = 32,
  localparam int PcW = $clog2(WordW + 1)
) (
  input  logic [WordW-1:0] bits,
  output logic [PcW-1:0]   count
);
  // Binary heap of adders: leaves at WordW-1 .. 2*WordW-2, root at 0
  logic [PcW-1:0] node [2*WordW-1];

  for (genvar i = 0; i < WordW; i++) begin : g_leaf
    assign node[WordW-1+i] = PcW'(bits[i]);
  end
  for (genvar j = 0; j < WordW-1; j++) begin : g_add
    assign node[j] = node[2*j+1] + node[2*j+2];
  end

  assign count = node[0];
endmodule

// File: rtl/bnn_cell_ctrl.sv
module bnn_cell_ctrl
  import bnn_cell_pkg::*;
#(
  parameter int Depth = 64,
  localparam int AddrW = $clog2(Depth)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inLast,
  input  logic             parMode,
  output cellCtrl_t        ctrl,
  output logic [AddrW-1:0] rdAddr,
  output logic             done
);
  logic [AddrW-1:0] wordPtr;

  assign rdAddr = inStart ? '0 : wordPtr;

  always_comb begin
    ctrl.first  = inValid & inStart;
    ctrl.seqAdd = inValid & ~parMode;
    ctrl.parOut = inValid & parMode;
    ctrl.finish = inValid & inLast & ~parMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordPtr <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctrl.finish;
      if (inValid) begin
        if (rdAddr == AddrW'(Depth-1)) wordPtr <= '0;
        else                           wordPtr <= rdAddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bnn_cell_datapath.sv
module bnn_cell_datapath
  import bnn_cell_pkg::*;
#(
  parameter int WordW = 32,
  parameter int Depth = 64,
  localparam int AddrW = $clog2(Depth),
  localparam int PcW   = $clog2(WordW + 1),
  localparam int AccW  = $clog2(WordW * Depth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellCtrl_t        ctrl,
  input  logic [AddrW-1:0] rdAddr,
  input  logic [WordW-1:0] inData,
  input  logic             wtWrEn,
  input  logic [AddrW-1:0] wtWrAddr,
  input  logic [WordW-1:0] wtWrData,
  input  logic             thrWrEn,
  input  logic [AccW-1:0]  thrWrData,
  output logic             actOut,
  output logic             partValid,
  output logic [PcW-1:0]   partCount
);
  logic [WordW-1:0] wMem [Depth];
  logic [AccW-1:0]  threshold;
  logic [AccW-1:0]  accum;
  logic [WordW-1:0] agreeBits;
  logic [PcW-1:0]   wordCount;
  logic [AccW-1:0]  accBase;
  logic [AccW-1:0]  accNext;
  logic [AccW:0]    margin;

  always_ff @(posedge clk) begin
    if (wtWrEn) wMem[wtWrAddr] <= wtWrData;
  end

  assign agreeBits = ~(inData ^ wMem[rdAddr]);

  bnn_popcount_tree #(.WordW(WordW)) u_tree (
    .bits  (agreeBits),
    .count (wordCount)
  );

  assign accBase = ctrl.first ? '0 : accum;
  assign accNext = accBase + AccW'(wordCount);
  // sign of (total - threshold): clear means total >= threshold
  assign margin  = {1'b0, accNext} - {1'b0, threshold};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threshold <= '0;
      accum     <= '0;
      actOut    <= 1'b0;
      partValid <= 1'b0;
      partCount <= '0;
    end else begin
      if (thrWrEn) threshold <= thrWrData;
      if (ctrl.seqAdd)     accum <= accNext;
      else if (ctrl.first) accum <= '0;
      if (ctrl.finish) actOut <= ~margin[AccW];
      partValid <= ctrl.parOut;
      if (ctrl.parOut) partCount <= wordCount;
    end
  end
endmodule

// File: rtl/bnn_neuron_cell.sv
module bnn_neuron_cell
  import bnn_cell_pkg::*;
#(
  parameter int WordW = 32,
  parameter int Depth = 64,
  localparam int AddrW = $clog2(Depth),
  localparam int PcW   = $clog2(WordW + 1),
  localparam int AccW  = $clog2(WordW * Depth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wtWrEn,
  input  logic [AddrW-1:0] wtWrAddr,
  input  logic [WordW-1:0] wtWrData,
  input  logic             thrWrEn,
  input  logic [AccW-1:0]  thrWrData,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inLast,
  input  logic             parMode,
  input  logic [WordW-1:0] inData,
  output logic             actOut,
  output logic             done,
  output logic             partValid,
  output logic [PcW-1:0]   partCount
);
  cellCtrl_t        ctrl;
  logic [AddrW-1:0] rdAddr;

  bnn_cell_ctrl #(.Depth(Depth)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .inLast  (inLast),
    .parMode (parMode),
    .ctrl    (ctrl),
    .rdAddr  (rdAddr),
    .done    (done)
  );

  bnn_cell_datapath #(.WordW(WordW), .Depth(Depth)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .rdAddr    (rdAddr),
    .inData    (inData),
    .wtWrEn    (wtWrEn),
    .wtWrAddr  (wtWrAddr),
    .wtWrData  (wtWrData),
    .thrWrEn   (thrWrEn),
    .thrWrData (thrWrData),
    .actOut    (actOut),
    .partValid (partValid),
    .partCount (partCount)
  );
endmodule

// File: rtl/bnn_cell_checker.sv
module bnn_cell_checker #(
  parameter int PcW = 6,
  parameter int WordW = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inLast,
  input logic           parMode,
  input logic           actOut,
  input logic           done,
  input logic           partValid,
  input logic [PcW-1:0] partCount
);
  // R5: done only follows a sequential last word
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(inValid && inLast && !parMode));

  // R7: part count is presented only after a parallel-mode word
  p_part_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    partValid |-> $past(inValid && parMode));

  // R7: a parallel word never completes a vector
  p_par_no_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && parMode) |-> !done);

  // R3: per-word count never exceeds the word width
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    partValid |-> (partCount <= PcW'(WordW)));

  // R6: activation changes only together with a completion
  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(actOut));

  // R1: outputs quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!done && !partValid && !actOut));
endmodule

bind bnn_neuron_cell bnn_cell_checker #(.PcW(PcW), .WordW(WordW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inLast    (inLast),
  .parMode   (parMode),
  .actOut    (actOut),
  .done      (done),
  .partValid (partValid),
  .partCount (partCount)
);

// File: tb/bnn_neuron_cell_bench.sv
module bnn_neuron_cell_bench;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wtWrEn = 1'b0;
  logic [5:0]  wtWrAddr = '0;
  logic [31:0] wtWrData = '0;
  logic        thrWrEn = 1'b0;
  logic [11:0] thrWrData = '0;
  logic        inValid = 1'b0;
  logic        inStart = 1'b0;
  logic        inLast = 1'b0;
  logic        parMode = 1'b0;
  logic [31:0] inData = '0;
  logic        actOut;
  logic        done;
  logic        partValid;
  logic [5:0]  partCount;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  bnn_neuron_cell u_bnn_neuron_cell (
    .clk(clk), .rstN(rstN),
    .wtWrEn(wtWrEn), .wtWrAddr(wtWrAddr), .wtWrData(wtWrData),
    .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .inValid(inValid), .inStart(inStart), .inLast(inLast),
    .parMode(parMode), .inData(inData),
    .actOut(actOut), .done(done), .partValid(partValid), .partCount(partCount)
  );

  function automatic logic [31:0] wfun(input int k);
    return (32'h9E3779B9 * 32'(k + 1)) ^ (32'(k) << 7) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] xfun(input int seed, input int k);
    return (32'h85EBCA6B * 32'(seed * 97 + k + 3)) ^ (32'hC2B2AE35 >> (k % 13));
  endfunction

  function automatic int pc(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [31:0] flipMask(input int n);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeThr(input int t);
    thrWrEn = 1'b1; thrWrData = 12'(t);
    @(negedge clk);
    thrWrEn = 1'b0;
  endtask

  // drive one word at a negedge; returns at next negedge with its results visible
  task automatic pushWord(input logic [31:0] x, input bit st, input bit ls, input bit par);
    inValid = 1'b1; inData = x; inStart = st; inLast = ls; parMode = par;
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inLast = 1'b0;
  endtask

  // full sequential vector starting at weight word 0
  task automatic seqCase(input int len, input int seed, input int delta, input string tag);
    int sum = 0;
    int thr;
    for (int k = 0; k < len; k++) sum += pc(~(xfun(seed, k) ^ wfun(k)));
    thr = sum + delta;
    if (thr < 0) thr = 0;
    writeThr(thr);
    for (int k = 0; k < len; k++) begin
      pushWord(xfun(seed, k), k == 0, k == len - 1, 1'b0);
      if (k == 0 && len > 1) chk({tag, " R5 no done mid-vector"}, int'(done), 0);
    end
    chk({tag, " R5 done after last"}, int'(done), 1);
    chk({tag, " R6 act ge threshold"}, int'(actOut), int'(sum >= thr));
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int sumA;
    int sumB;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 act", int'(actOut), 0);
    chk("R1 partValid", int'(partValid), 0);
    chk("R1 partCount", int'(partCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release done", int'(done), 0);

    for (int k = 0; k < 64; k++) begin
      wtWrEn = 1'b1; wtWrAddr = 6'(k); wtWrData = wfun(k);
      @(negedge clk);
    end
    wtWrEn = 1'b0;

    // R2/R3/R4: parallel sweep, each word gets k%33 agreeing bits
    for (int k = 0; k < 64; k++) begin
      int want = k % 33;
      pushWord(wfun(k) ^ flipMask(32 - want), k == 0, 1'b0, 1'b1);
      chk("R7 partValid", int'(partValid), 1);
      chk($sformatf("R2 R3 R4 count word %0d", k), int'(partCount), want);
      chk("R7 no done in parallel", int'(done), 0);
    end
    // R4 wrap: next word uses weight 0 again
    pushWord(wfun(0), 1'b0, 1'b0, 1'b1);
    chk("R4 pointer wrap", int'(partCount), 32);
    // R4 restart on start marker
    pushWord(wfun(1), 1'b0, 1'b0, 1'b1);
    pushWord(wfun(0), 1'b1, 1'b0, 1'b1);
    chk("R4 restart to word 0", int'(partCount), 32);
    @(negedge clk);
    chk("R7 partValid drops", int'(partValid), 0);

    // R5/R6/R9: several lengths and thresholds
    for (int s = 0; s < 3; s++) begin
      seqCase(1, s, 0, "len1 eq");
      seqCase(2, s + 10, 1, "len2 above");
      seqCase(5, s + 20, -1, "len5 below");
      seqCase(5, s + 20, 1, "len5 above");
      seqCase(64, s + 30, 0, "len64 eq");
      seqCase(64, s + 30, 1, "len64 above R9");
    end

    // R10: full match 64 words
    writeThr(2048);
    for (int k = 0; k < 64; k++) pushWord(wfun(k), k == 0, k == 63, 1'b0);
    chk("R10 2048 reaches threshold", int'(actOut), 1);
    writeThr(2049);
    for (int k = 0; k < 64; k++) pushWord(wfun(k), k == 0, k == 63, 1'b0);
    chk("R10 2048 below 2049", int'(actOut), 0);

    // R8: abandoned partial vector then restart with single word
    writeThr(0);
    for (int k = 0; k < 3; k++) pushWord(wfun(k), k == 0, 1'b0, 1'b0);
    sumA = pc(~(xfun(7, 0) ^ wfun(0)));
    writeThr(sumA + 1);
    pushWord(xfun(7, 0), 1'b1, 1'b1, 1'b0);
    chk("R8 start-and-last done", int'(done), 1);
    chk("R8 stale total discarded", int'(actOut), 0);
    writeThr(sumA);
    pushWord(xfun(7, 0), 1'b1, 1'b1, 1'b0);
    chk("R8 single word equals thr", int'(actOut), 1);

    // R7: parallel words inside a sequential vector are not added
    sumB = pc(~(xfun(9, 0) ^ wfun(0))) + pc(~(xfun(9, 3) ^ wfun(3)));
    writeThr(sumB + 1);
    pushWord(xfun(9, 0), 1'b1, 1'b0, 1'b0);
    pushWord(wfun(1), 1'b0, 1'b0, 1'b1);
    chk("R7 parallel count", int'(partCount), 32);
    pushWord(wfun(2), 1'b0, 1'b0, 1'b1);
    pushWord(xfun(9, 3), 1'b0, 1'b1, 1'b0);
    chk("R7 done after mixed vector", int'(done), 1);
    chk("R7 parallel words excluded", int'(actOut), 0);
    writeThr(sumB);
    pushWord(xfun(9, 0), 1'b1, 1'b0, 1'b0);
    pushWord(wfun(1), 1'b0, 1'b0, 1'b1);
    pushWord(wfun(2), 1'b0, 1'b0, 1'b1);
    pushWord(xfun(9, 3), 1'b0, 1'b1, 1'b0);
    chk("R7 R9 mixed equals thr", int'(actOut), 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule